// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames from a byte stream into host memory buffers. Software describes the buffers with a ring of descriptors. Each descriptor is four 32-bit words in a fixed order: status at +0, control at +4, buffer address at +8 and next address at +12. Software hands a descriptor to the hardware by setting its ownership bit. When a frame begins, the block reads the current descriptor. If software owns that descriptor, the block packs the frame bytes into 32-bit words and writes them to the buffer. It then writes back a status word that clears ownership and reports the frame length and the error state.

Descriptors lie 16 bytes apart. A ring-end flag in the control word sends the pointer back to the programmed ring base. A frame that arrives while the current descriptor is still held by software is consumed and discarded. A missed-frame counter records each such frame, and the same descriptor is tried again for the next frame. All memory traffic uses a single request/acknowledge port with one access outstanding.

Top module: `rxRingWriter`

## Requirements
- R1: After reset, inReady is 0, memReq is 0, missCount is 0, and the ring base and descriptor pointer are 0.
- R2: When inValid rises while the block is idle, the block reads the status word at the descriptor pointer, then the control word at pointer+4, then the buffer address at pointer+8, in that order, before it accepts any byte.
- R3: If bit 31 (ownership) of the fetched status word is 0, the block accepts and discards every byte up to and including the one flagged inLast. It makes no memory write, increments missCount by one, and leaves the pointer unchanged, so the next frame reads the same descriptor.
- R4: Frame bytes are stored little-endian. Byte n goes to lane n mod 4 of the word at buffer address + 4*(n/4). A final partial word is written with its unused upper lanes set to zero, and no word beyond the last stored byte is written.
- R5: After the data, the block writes the status word at the descriptor pointer as follows: bit 31 = 0, bits 30:16 = the number of bytes stored (the stream's trailing 4 CRC bytes are included), bit 8 = 1, bit 15 = error summary, and all other bits 0.
- R6: If inErr is 1 together with the byte flagged inLast, status bit 15 is set.
- R7: The buffer size is control word bits 10:0. Bytes beyond that size are accepted but not written, status bit 15 is set, and the length field equals the size. A frame of exactly the size sets no error.
- R8: After the status write-back, the pointer advances by 16. If bit 25 of the control word was set, the pointer returns to the ring base instead.
- R9: A pulse on baseWe loads baseIn into both the ring base and the descriptor pointer. It is only legal while idle.
- R10: memReq, once raised, stays high with memAddr, memWrite and memWdata stable until the cycle in which memAck is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| baseWe | input | 1 | Write strobe for the ring base register |
| baseIn | input | AW | New ring base byte address |
| inValid | input | 1 | Stream byte valid |
| inByte | input | 8 | Stream byte |
| inLast | input | 1 | Marks the final byte of a frame |
| inErr | input | 1 | Frame error flag, qualified by inLast |
| inReady | output | 1 | Block accepts the stream byte this cycle |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWrite | output | 1 | 1 for write, 0 for read |
| memAddr | output | AW | Byte address, word aligned |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | One-cycle completion of the pending access |
| memRdata | input | 32 | Read data, valid with memAck |
| missCount | output | MISS_W | Frames discarded for lack of an owned descriptor |

## Verification
Every result of this block lands in memory. The data words appear one acknowledged write after the fourth byte of each group or after the last byte. The status word follows one more acknowledged write later, and the pointer moves in the edge that accepts the status acknowledge. The bench's memory model answers each access after a fixed latency, so a frame of at most nine bytes is complete well inside the 100 cycles that each scenario waits. Memory contents, the read log and missCount are therefore sampled on a falling edge after that window. The handshake rule is checked on every cycle by a monitor that compares each held request with the one from the previous cycle.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int LEN_W = 15;

  typedef enum logic [1:0] {SEL_ST, SEL_CTL, SEL_BUF, SEL_DATA} addrSel_e;

  typedef struct packed {
    logic     start;
    logic     capCtl;
    logic     capBuf;
    logic     accept;
    logic     wrDone;
    logic     advance;
    logic     missInc;
    addrSel_e addrSel;
  } ctlStrobe_t;

  typedef struct packed {
    logic ownBit;
    logic fits;
    logic laneFull;
    logic pend;
    logic lastSeen;
  } dpStatus_t;
endpackage

// File: rtl/rxr_ctl.sv
module rxr_ctl
  import rxr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLast,
  output logic       inReady,
  input  logic       memAck,
  output logic       memReq,
  output logic       memWrite,
  input  dpStatus_t  dpSt,
  output ctlStrobe_t cs
);
  typedef enum logic [2:0] {IDLE, RD_ST, RD_CTL, RD_BUF, RECV, WR_DATA, WR_ST, DROP} state_e;
  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt      = state;
    cs       = '0;
    cs.addrSel = SEL_ST;
    inReady  = 1'b0;
    memReq   = 1'b0;
    memWrite = 1'b0;
    case (state)
      IDLE: if (inValid) begin cs.start = 1'b1; nxt = RD_ST; end
      RD_ST: begin
        memReq = 1'b1;
        if (memAck) begin
          cs.missInc = !dpSt.ownBit;
          nxt = dpSt.ownBit ? RD_CTL : DROP;
        end
      end
      RD_CTL: begin
        memReq = 1'b1; cs.addrSel = SEL_CTL;
        if (memAck) begin cs.capCtl = 1'b1; nxt = RD_BUF; end
      end
      RD_BUF: begin
        memReq = 1'b1; cs.addrSel = SEL_BUF;
        if (memAck) begin cs.capBuf = 1'b1; nxt = RECV; end
      end
      RECV: begin
        inReady = 1'b1;
        if (inValid) begin
          cs.accept = 1'b1;
          if (dpSt.fits && dpSt.laneFull) nxt = WR_DATA;
          else if (inLast) nxt = (dpSt.pend || dpSt.fits) ? WR_DATA : WR_ST;
        end
      end
      WR_DATA: begin
        memReq = 1'b1; memWrite = 1'b1; cs.addrSel = SEL_DATA;
        if (memAck) begin cs.wrDone = 1'b1; nxt = dpSt.lastSeen ? WR_ST : RECV; end
      end
      WR_ST: begin
        memReq = 1'b1; memWrite = 1'b1;
        if (memAck) begin cs.advance = 1'b1; nxt = IDLE; end
      end
      DROP: begin
        inReady = 1'b1;
        if (inValid && inLast) nxt = IDLE;
      end
      default: nxt = IDLE;
    endcase
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWrite));

  // R2
  no_accept_during_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !inReady);
endmodule

// File: rtl/rxr_dp.sv
module rxr_dp
  import rxr_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 11,
  parameter int MISS_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWe,
  input  logic [AW-1:0]     baseIn,
  input  logic [7:0]        inByte,
  input  logic              inLast,
  input  logic              inErr,
  input  logic [31:0]       memRdata,
  input  ctlStrobe_t        cs,
  output dpStatus_t         dpSt,
  output logic [AW-1:0]     memAddr,
  output logic [31:0]       memWdata,
  output logic [MISS_W-1:0] missCount
);
  localparam logic [AW-1:0] DESC_STRIDE = AW'(16);
  localparam int RING_END_BIT = 25;
  localparam int OWN_BIT      = 31;

  logic [AW-1:0]     ringBase, descAddr, bufAddr;
  logic [SIZE_W-1:0] bufSize;
  logic              ringEnd, trunc, frameErr, pend, lastSeen;
  logic [LEN_W-1:0]  storedCnt, lastIdx;
  logic [31:0]       wordBuf, statusWord;
  logic [1:0]        lane;

  assign lane          = storedCnt[1:0];
  assign lastIdx       = storedCnt - LEN_W'(1);
  assign dpSt.ownBit   = memRdata[OWN_BIT];
  assign dpSt.fits     = storedCnt < LEN_W'(bufSize);
  assign dpSt.laneFull = (lane == 2'd3);
  assign dpSt.pend     = pend;
  assign dpSt.lastSeen = lastSeen;

  assign statusWord = {1'b0, storedCnt, trunc | frameErr, 6'b0, 1'b1, 8'b0};

  always_comb begin
    case (cs.addrSel)
      SEL_CTL:  memAddr = descAddr + AW'(4);
      SEL_BUF:  memAddr = descAddr + AW'(8);
      SEL_DATA: memAddr = bufAddr + AW'({lastIdx[LEN_W-1:2], 2'b00});
      default:  memAddr = descAddr;
    endcase
    memWdata = (cs.addrSel == SEL_DATA) ? wordBuf : statusWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ringBase <= '0; descAddr <= '0; bufAddr <= '0; bufSize <= '0;
      ringEnd <= 1'b0; trunc <= 1'b0; frameErr <= 1'b0; pend <= 1'b0;
      lastSeen <= 1'b0; storedCnt <= '0; wordBuf <= '0; missCount <= '0;
    end else begin
      if (baseWe) begin
        ringBase <= baseIn;
        descAddr <= baseIn;
      end else if (cs.advance) begin
        descAddr <= ringEnd ? ringBase : descAddr + DESC_STRIDE;
      end
      if (cs.start) begin
        storedCnt <= '0; trunc <= 1'b0; frameErr <= 1'b0;
        pend <= 1'b0; lastSeen <= 1'b0;
      end
      if (cs.capCtl) begin
        bufSize <= memRdata[SIZE_W-1:0];
        ringEnd <= memRdata[RING_END_BIT];
      end
      if (cs.capBuf) bufAddr <= memRdata[AW-1:0];
      if (cs.accept) begin
        if (inLast) begin
          lastSeen <= 1'b1;
          frameErr <= inErr;
        end
        if (dpSt.fits) begin
          if (lane == 2'd0) wordBuf <= {24'b0, inByte};
          else              wordBuf[8*lane +: 8] <= inByte;
          storedCnt <= storedCnt + LEN_W'(1);
          pend      <= 1'b1;
        end else begin
          trunc <= 1'b1;
        end
      end
      if (cs.wrDone) pend <= 1'b0;
      if (cs.missInc) missCount <= missCount + MISS_W'(1);
    end
  end

  // R7
  stored_within_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    storedCnt <= LEN_W'(bufSize) || storedCnt == '0);

  // R8
  ring_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    cs.advance && ringEnd && !baseWe |=> descAddr == $past(ringBase));

  // R8
  ring_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    cs.advance && !ringEnd && !baseWe |=> descAddr == $past(descAddr) + DESC_STRIDE);

  // R3
  miss_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    cs.missInc |=> missCount == $past(missCount) + MISS_W'(1) && $stable(descAddr));
endmodule

// File: rtl/rxRingWriter.sv
module rxRingWriter
  import rxr_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 11,
  parameter int MISS_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWe,
  input  logic [AW-1:0]     baseIn,
  input  logic              inValid,
  input  logic [7:0]        inByte,
  input  logic              inLast,
  input  logic              inErr,
  output logic              inReady,
  output logic              memReq,
  output logic              memWrite,
  output logic [AW-1:0]     memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic [MISS_W-1:0] missCount
);
  ctlStrobe_t cs;
  dpStatus_t  dpSt;

  rxr_ctl i_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .memAck(memAck), .memReq(memReq), .memWrite(memWrite), .dpSt(dpSt), .cs(cs)
  );

  rxr_dp #(.AW(AW), .SIZE_W(SIZE_W), .MISS_W(MISS_W)) i_dp (
    .clk(clk), .rstN(rstN), .baseWe(baseWe), .baseIn(baseIn), .inByte(inByte),
    .inLast(inLast), .inErr(inErr), .memRdata(memRdata), .cs(cs), .dpSt(dpSt),
    .memAddr(memAddr), .memWdata(memWdata), .missCount(missCount)
  );

  // R10
  addr_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memWdata));

  // R4
  aligned_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00);
endmodule

// File: tb/test_rxRingWriter.sv
`timescale 1ns/1ps
module test_rxRingWriter;
  localparam int AW = 32;
  localparam int LAT = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic baseWe = 1'b0; logic [AW-1:0] baseIn = '0;
  logic inValid = 1'b0, inLast = 1'b0, inErr = 1'b0; logic [7:0] inByte = '0;
  logic inReady, memReq, memWrite, memAck; logic [AW-1:0] memAddr;
  logic [31:0] memWdata, memRdata; logic [7:0] missCount;

  int total = 0, bad = 0;
  logic [31:0] mem [0:63];
  logic busy = 1'b0, opW = 1'b0; logic [1:0] lat = '0; logic [31:0] opA = '0, opD = '0;
  int wrCount = 0, readIdx = 0, hsBad = 0;
  logic [31:0] readLog [0:3];
  logic prevHold = 1'b0; logic [31:0] prevA = '0, prevD = '0; logic prevW = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  rxRingWriter i_rxRingWriter (
    .clk(clk), .rstN(rstN), .baseWe(baseWe), .baseIn(baseIn), .inValid(inValid),
    .inByte(inByte), .inLast(inLast), .inErr(inErr), .inReady(inReady),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .missCount(missCount)
  );

  initial begin memAck = 1'b0; memRdata = '0; end

  always @(posedge clk) begin
    memAck <= 1'b0;
    if (busy) begin
      if (lat == 2'd0) begin
        busy <= 1'b0; memAck <= 1'b1;
        if (opW) begin mem[opA[7:2]] <= opD; wrCount <= wrCount + 1; end
        else memRdata <= mem[opA[7:2]];
      end else lat <= lat - 2'd1;
    end else if (rstN && memReq && !memAck) begin
      busy <= 1'b1; lat <= 2'(LAT - 1); opA <= memAddr; opD <= memWdata; opW <= memWrite;
      if (!memWrite && readIdx < 4) begin readLog[readIdx] <= memAddr; readIdx <= readIdx + 1; end
    end
    if (rstN && prevHold && (!memReq || memAddr != prevA || memWdata != prevD || memWrite != prevW))
      hsBad <= hsBad + 1;
    prevHold <= rstN && memReq && !memAck;
    prevA <= memAddr; prevD <= memWdata; prevW <= memWrite;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setDesc(input logic [31:0] a, input logic [31:0] st, input logic [31:0] ctl,
                         input logic [31:0] buff);
    mem[a[7:2]] = st; mem[a[7:2] + 1] = ctl; mem[a[7:2] + 2] = buff; mem[a[7:2] + 3] = 32'h0;
  endtask

  task automatic sendFrame(input int n, input logic [7:0] seed, input logic err);
    readIdx = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b1; inByte = seed + 8'(i); inLast = (i == n - 1); inErr = err && (i == n - 1);
      while (!inReady) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0; inErr = 1'b0;
    waitCycles(100);
  endtask

  task automatic writeBase(input logic [31:0] b);
    @(negedge clk); baseWe = 1'b1; baseIn = b;
    @(negedge clk); baseWe = 1'b0;
  endtask

  task automatic testReset;
    chk("R1 inReady", {31'b0, inReady}, 32'h0);
    chk("R1 memReq", {31'b0, memReq}, 32'h0);
    chk("R1 missCount", {24'b0, missCount}, 32'h0);
  endtask

  task automatic testNormal;
    writeBase(32'h40);
    setDesc(32'h40, 32'h8000_0000, 32'd64, 32'h80);
    sendFrame(6, 8'h10, 1'b0);
    chk("R2 read0", readLog[0], 32'h40);
    chk("R2 read1", readLog[1], 32'h44);
    chk("R2 read2", readLog[2], 32'h48);
    chk("R4 word0", mem[32], 32'h1312_1110);
    chk("R4 partial", mem[33], 32'h0000_1514);
    chk("R5 status", mem[16], 32'h0006_0100);
  endtask

  task automatic testErr;
    setDesc(32'h50, 32'h8000_0000, 32'd64, 32'h90);
    mem[37] = 32'h0;
    sendFrame(4, 8'h20, 1'b1);
    chk("R8 step read", readLog[0], 32'h50);
    chk("R4 full word", mem[36], 32'h2322_2120);
    chk("R4 no extra word", mem[37], 32'h0);
    chk("R6 status", mem[20], 32'h0004_8100);
  endtask

  task automatic testTrunc;
    setDesc(32'h60, 32'h8000_0000, (32'h1 << 25) | 32'd5, 32'hA0);
    for (int k = 40; k < 44; k++) mem[k] = 32'hDEAD_BEEF;
    sendFrame(9, 8'h30, 1'b0);
    chk("R7 word0", mem[40], 32'h3332_3130);
    chk("R7 word1", mem[41], 32'h0000_0034);
    chk("R7 untouched", mem[42], 32'hDEAD_BEEF);
    chk("R7 status", mem[24], 32'h0005_8100);
  endtask

  task automatic testWrap;
    setDesc(32'h40, 32'h8000_0000, 32'd64, 32'hB0);
    sendFrame(3, 8'h40, 1'b0);
    chk("R8 wrap read", readLog[0], 32'h40);
    chk("R8 wrap data", mem[44], 32'h0042_4140);
    chk("R8 wrap status", mem[16], 32'h0003_0100);
  endtask

  task automatic testMissed;
    int w0;
    w0 = wrCount;
    sendFrame(5, 8'h70, 1'b0);
    chk("R3 no writes", 32'(wrCount - w0), 32'h0);
    chk("R3 missCount", {24'b0, missCount}, 32'h1);
    chk("R3 status kept", mem[20], 32'h0004_8100);
    setDesc(32'h50, 32'h8000_0000, 32'd64, 32'hC0);
    sendFrame(2, 8'h50, 1'b0);
    chk("R3 retry read", readLog[0], 32'h50);
    chk("R3 retry data", mem[48], 32'h0000_5150);
    chk("R3 retry status", mem[20], 32'h0002_0100);
  endtask

  task automatic testBase;
    writeBase(32'h70);
    setDesc(32'h70, 32'h8000_0000, 32'd64, 32'hD0);
    sendFrame(1, 8'h60, 1'b0);
    chk("R9 read0", readLog[0], 32'h70);
    chk("R9 read2", readLog[2], 32'h78);
    chk("R9 data", mem[52], 32'h0000_0060);
    chk("R9 status", mem[28], 32'h0001_0100);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 32'h0;
    for (int k = 0; k < 4; k++) readLog[k] = 32'h0;
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    waitCycles(2);
    testNormal();
    testErr();
    testTrunc();
    testWrap();
    testMissed();
    testBase();
    chk("R10 handshake", 32'(hsBad), 32'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule